// File: doc/BRIEF.md
# Toggle-Qualified Bus Synchronizer

This block carries a multi-bit word from one clock domain to another clock domain whose clock is unrelated to the first. On the source side, a send strobe accepted while the block is idle does two things on the same edge. It copies the input word into a holding register, and it inverts a one-bit request flag. Only that flag crosses the boundary, through a chain of flip-flops. The word itself is never synchronized; it is simply kept still until the destination has taken it.

In the destination domain, the synchronized flag is compared with a registered copy of itself. When the two differ, the block loads the held word into an output register and raises a valid pulse for one cycle. The registered copy of the flag goes back to the source domain as an acknowledge and passes through a second flop chain there. The source reports busy from the accepting edge until that acknowledge catches up with its own request flag. Send strobes that arrive while busy is high are discarded.

Top module: `tsync_bus_xfer`

## Requirements
- R1: When src_send is 1 and src_busy is 0 at a rising src_clk edge, the block accepts the word on src_word, and src_busy reads 1 after that edge.
- R2: A send strobe seen while src_busy is 1 is discarded. It starts no transfer, produces no extra dst_valid pulse, and does not alter the word already in flight.
- R3: Every accepted word appears on dst_word exactly once, bit for bit unchanged, in the same order in which the words were accepted.
- R4: dst_valid is high for exactly one dst_clk cycle per transfer. dst_word changes only on the edge that raises dst_valid and keeps its value until the next delivery.
- R5: With the default two synchronizer stages, dst_valid and the new dst_word appear after the third rising dst_clk edge that falls strictly later than the accepting src_clk edge. That is two to three destination periods after the accepting edge.
- R6: src_busy stays 1 until the second rising src_clk edge strictly after the delivering dst_clk edge, and falls after that edge. The held word does not change while src_busy is 1.
- R7: While src_rst and dst_rst are high, and afterwards until the first accepted send, src_busy, dst_valid and dst_word are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_send | input | 1 | Request to transfer src_word |
| src_word | input | WIDTH | Word to be transferred |
| src_busy | output | 1 | A transfer is in flight; new sends are discarded |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_word | output | WIDTH | Last delivered word |
| dst_valid | output | 1 | One-cycle pulse marking a new dst_word |

## Verification
The assertions assume that both resets are applied together and released while no transfer is pending. They also assume that src_send and src_word are stable around every rising src_clk edge. The bench meets these assumptions by asserting both resets at time zero and driving every input on the falling source edge. The clocks run at unrelated, non-integer-ratio periods, and their relative speed is reversed partway through the run. Both sparse sends and a strobe held high continuously are used, so that many requests land while busy is high.

// File: rtl/tsync_pkg.sv
`timescale 1ns/1ps
package tsync_pkg;

    localparam int unsigned DEF_WIDTH  = 16;
    localparam int unsigned DEF_STAGES = 2;

    // A toggle flag has moved when its current and previous samples differ.
    function automatic logic flag_moved(input logic now_v, input logic prev_v);
        return now_v ^ prev_v;
    endfunction

    // The source is busy while its request flag and the returned acknowledge differ.
    function automatic logic flags_differ(input logic req_v, input logic ack_v);
        return req_v ^ ack_v;
    endfunction

endpackage

// File: rtl/tsync_flop_chain.sv
`timescale 1ns/1ps
module tsync_flop_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // Stage 0 may go metastable; only the last stage drives logic.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[LAST];
endmodule

// File: rtl/tsync_src.sv
`timescale 1ns/1ps
module tsync_src
    import tsync_pkg::*;
#(
    parameter int unsigned WIDTH  = DEF_WIDTH,
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             send,
    input  logic [WIDTH-1:0] word_in,
    input  logic             ack_tog,
    output logic             busy,
    output logic             req_tog,
    output logic [WIDTH-1:0] hold_word
);
    logic ack_s;
    logic accept;

    tsync_flop_chain #(.STAGES(STAGES)) i_ack_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (ack_tog),
        .q_sync  (ack_s)
    );

    assign busy   = flags_differ(req_tog, ack_s);
    assign accept = send & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_tog   <= 1'b0;
            hold_word <= '0;
        end else if (accept) begin
            req_tog   <= ~req_tog;
            hold_word <= word_in;
        end
    end

    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
        (send && !busy) |=> busy);

    assert_busy_send_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (send && busy) |=> ($stable(req_tog) && $stable(hold_word)));

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(hold_word));
endmodule

// File: rtl/tsync_dst.sv
`timescale 1ns/1ps
module tsync_dst
    import tsync_pkg::*;
#(
    parameter int unsigned WIDTH  = DEF_WIDTH,
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_tog,
    input  logic [WIDTH-1:0] hold_word,
    output logic [WIDTH-1:0] word_out,
    output logic             valid,
    output logic             ack_tog
);
    logic req_s;
    logic prev_q;
    logic moved;

    tsync_flop_chain #(.STAGES(STAGES)) i_req_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (req_tog),
        .q_sync  (req_s)
    );

    assign moved = flag_moved(req_s, prev_q);

    // The held word is sampled only when the synchronized flag has moved.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            valid    <= 1'b0;
            word_out <= '0;
        end else begin
            prev_q <= req_s;
            valid  <= moved;
            if (moved) word_out <= hold_word;
        end
    end

    assign ack_tog = prev_q;

    assert_valid_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    assert_word_changes_with_valid_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(word_out) |-> valid);
endmodule

// File: rtl/tsync_bus_xfer.sv
`timescale 1ns/1ps
module tsync_bus_xfer
    import tsync_pkg::*;
#(
    parameter int unsigned WIDTH       = DEF_WIDTH,
    parameter int unsigned SYNC_STAGES = DEF_STAGES
) (
    input  logic             src_clk,
    input  logic             src_rst,
    input  logic             src_send,
    input  logic [WIDTH-1:0] src_word,
    output logic             src_busy,
    input  logic             dst_clk,
    input  logic             dst_rst,
    output logic [WIDTH-1:0] dst_word,
    output logic             dst_valid
);
    logic             req_tog;
    logic             ack_tog;
    logic [WIDTH-1:0] hold_word;

    tsync_src #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_src (
        .clk       (src_clk),
        .rst       (src_rst),
        .send      (src_send),
        .word_in   (src_word),
        .ack_tog   (ack_tog),
        .busy      (src_busy),
        .req_tog   (req_tog),
        .hold_word (hold_word)
    );

    tsync_dst #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_dst (
        .clk       (dst_clk),
        .rst       (dst_rst),
        .req_tog   (req_tog),
        .hold_word (hold_word),
        .word_out  (dst_word),
        .valid     (dst_valid),
        .ack_tog   (ack_tog)
    );
endmodule

// File: tb/test_tsync_bus_xfer.sv
`timescale 1ns/1ps
module test_tsync_bus_xfer;
    localparam int W = 16;

    logic         src_clk = 1'b0, dst_clk = 1'b0;
    logic         src_rst = 1'b1, dst_rst = 1'b1;
    logic         src_send = 1'b0;
    logic [W-1:0] src_word = '0;
    logic         src_busy, dst_valid;
    logic [W-1:0] dst_word;

    real src_half = 5.0;
    real dst_half = 6.85;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Reference model state: counters written by one process each.
    int           acc_cnt = 0;     // src posedge process
    logic [W-1:0] pend_word = '0;  // src posedge process
    real          pend_t = 0.0;    // src posedge process
    int           ack_done = 0;    // src posedge process
    int           ack_edges = 0;   // src posedge process
    int           del_cnt = 0;     // dst posedge process
    int           pend_edges = 0;  // dst posedge process
    bit           exp_valid = 1'b0;// dst posedge process
    logic [W-1:0] exp_word = '0;   // dst posedge process
    int           ack_cnt = 0;     // dst posedge process
    real          ack_t = 0.0;     // dst posedge process

    tsync_bus_xfer #(.WIDTH(W), .SYNC_STAGES(2)) i_tsync_bus_xfer (
        .src_clk   (src_clk),
        .src_rst   (src_rst),
        .src_send  (src_send),
        .src_word  (src_word),
        .src_busy  (src_busy),
        .dst_clk   (dst_clk),
        .dst_rst   (dst_rst),
        .dst_word  (dst_word),
        .dst_valid (dst_valid)
    );

    always #(src_half) src_clk = ~src_clk;
    always #(dst_half) dst_clk = ~dst_clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $realtime);
        end
    endtask

    // Source edge: model acceptance (R1) and the acknowledge return (R6).
    always @(posedge src_clk) begin
        if (!src_rst) begin
            if (ack_cnt != ack_done && $realtime > ack_t) begin
                ack_edges++;
                if (ack_edges == 2) begin
                    ack_done++;
                    ack_edges = 0;
                end
            end
            if (src_send && !src_busy) begin
                acc_cnt++;
                pend_word = src_word;
                pend_t = $realtime;
            end
        end
    end

    // Destination edge: count edges after acceptance, deliver on the third (R5).
    always @(posedge dst_clk) begin
        exp_valid = 1'b0;
        if (!dst_rst && acc_cnt != del_cnt && $realtime > pend_t) begin
            pend_edges++;
            if (pend_edges == 3) begin
                exp_valid = 1'b1;
                exp_word = pend_word;
                del_cnt++;
                pend_edges = 0;
                ack_t = $realtime;
                ack_cnt++;
            end
        end
    end

    // Compare every destination cycle: R3 word, R4/R5 pulse timing, R2 no extra pulse.
    always @(negedge dst_clk) begin
        if (!dst_rst && !finished) begin
            chk(dst_valid == exp_valid, "R4 R5 R2 dst_valid", 64'(dst_valid), 64'(exp_valid));
            chk(dst_word == exp_word, "R3 R4 dst_word", 64'(dst_word), 64'(exp_word));
        end
    end

    // Compare every source cycle: R1 busy rise, R6 busy fall timing.
    always @(negedge src_clk) begin
        if (!src_rst && !finished)
            chk(src_busy == (acc_cnt != ack_done), "R1 R6 src_busy",
                64'(src_busy), 64'(acc_cnt != ack_done));
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge src_clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R7: reset state while both resets are held.
        repeat (6) @(negedge src_clk);
        chk(src_busy == 1'b0, "R7 busy in reset", 64'(src_busy), 64'd0);
        chk(dst_valid == 1'b0, "R7 valid in reset", 64'(dst_valid), 64'd0);
        chk(dst_word == '0, "R7 word in reset", 64'(dst_word), 64'd0);
        src_rst <= 1'b0;
        dst_rst <= 1'b0;
        // R7: idle after reset, no pulse without a send (checked per cycle).
        repeat (40) @(negedge src_clk);
        chk(dst_valid == 1'b0 && src_busy == 1'b0, "R7 idle after reset",
            64'({dst_valid, src_busy}), 64'd0);

        // Phase A: destination slower, sparse sends.
        for (int i = 0; i < 3000; i++) begin
            @(negedge src_clk);
            src_send <= ($urandom % 3) == 0;
            src_word <= W'($urandom);
        end
        // Phase B: destination faster, strobe held high (R2 sends while busy).
        dst_half = 2.15;
        for (int i = 0; i < 3000; i++) begin
            @(negedge src_clk);
            src_send <= 1'b1;
            src_word <= W'($urandom);
        end
        // Phase C: destination much slower, bursts.
        dst_half = 17.3;
        for (int i = 0; i < 2000; i++) begin
            @(negedge src_clk);
            src_send <= (i % 7) < 4;
            src_word <= W'($urandom);
        end
        @(negedge src_clk);
        src_send <= 1'b0;
        repeat (60) @(negedge src_clk);
        // R3: every accepted word delivered exactly once.
        chk(acc_cnt == del_cnt && src_busy == 1'b0, "R3 all words delivered",
            64'(del_cnt), 64'(acc_cnt));
        chk(acc_cnt > 100, "R1 enough transfers accepted", 64'(acc_cnt), 64'd101);
        finish_run();
    end
endmodule